// File: doc/BRIEF.md
# ISA Memory-Window Address Decoder

This block watches ISA memory cycles and decides whether the host is addressing a 4 KB window. The window exposes the internal packet memory of a network controller and can be moved anywhere the host chooses. Software writes the window base into a base register. It then sets an enable bit and a path-select bit in a control register. On every access that falls in the window, the block raises a hit strobe and passes the low twelve address bits out as the offset into internal memory.

There are two decode paths. The full-range path covers the whole 16 MB space. It compares the upper address nibble, taken from the latchable address lines and captured while the address-latch strobe is high, together with system address bits 19..12. The low-megabyte path uses only the system address lines, and it requires the upper nibble of the base to be zero. The two paths are qualified by different strobe pairs: the full-range path by the general memory read and write strobes, the low-megabyte path by the below-1 MB read and write strobes.

Top module: `isa_mem_window`

## Requirements
- R1: After reset, win_hit stays low whatever the address and strobe inputs are, until software enables decoding.
- R2: While the enable bit (control register bit 10) is 0, win_hit is 0.
- R3: With enable=1 and path-select (control register bit 9) = 0, win_hit is 1 when the latched upper nibble joined with sa[19:12] equals the base and memr_n or memw_n is low.
- R4: la is captured on each rising clock edge where bale is high. While bale is low, changes on la do not change the decode.
- R5: With path-select=1, only smemr_n and smemw_n qualify a hit. memr_n and memw_n are ignored, and a hit needs sa[19:12] to equal base bits 7..0.
- R6: With path-select=1, a base whose bits 11..8 (address bits 23..20) are not zero never produces a hit.
- R7: With none of the strobes qualifying the selected path active, win_hit is 0.
- R8: win_off always equals sa[11:0].
- R9: A write with cfg_sel=0 loads cfg_wdata[11:0] as window base address bits 23..12. A write with cfg_sel=1 loads the enable bit from cfg_wdata[10] and path-select from cfg_wdata[9]. All other data bits are ignored.
- R10: An address whose upper bits differ from the base gives no hit, in either path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the control register |
| cfg_wdata | input | 16 | Register write data |
| bale | input | 1 | Address-latch strobe, high while la is valid |
| la | input | 4 | Latchable address bits 23..20 |
| sa | input | 20 | System address bits 19..0 |
| memr_n | input | 1 | Memory read strobe, full range, active low |
| memw_n | input | 1 | Memory write strobe, full range, active low |
| smemr_n | input | 1 | Memory read strobe, below 1 MB, active low |
| smemw_n | input | 1 | Memory write strobe, below 1 MB, active low |
| win_hit | output | 1 | Access falls inside the window |
| win_off | output | 12 | Offset into internal memory |

## Verification
The bench changes la while bale is low and expects the hit to follow the old latched nibble; a design that decoded la directly would drop or invent hits. It applies the strobes of the wrong path in each mode, where a design that ORed all four strobes would hit on cycles meant for other memory. It programs a low-megabyte base with a non-zero upper nibble, which a design that skipped that check would alias into the first megabyte. It also writes a control word with every bit set except the enable bit, catching any design that decodes the enable from the wrong bit position.

// File: rtl/isa_mem_window.sv
module isa_mem_window #(
  parameter int ADDR_W  = 24,
  parameter int SA_W    = 20,
  parameter int WIN_W   = 12,
  parameter int REG_W   = 16,
  parameter int EN_BIT  = 10,
  parameter int SEL_BIT = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_sel,
  input  logic [REG_W-1:0]          cfg_wdata,
  input  logic                      bale,
  input  logic [ADDR_W-SA_W-1:0]    la,
  input  logic [SA_W-1:0]           sa,
  input  logic                      memr_n,
  input  logic                      memw_n,
  input  logic                      smemr_n,
  input  logic                      smemw_n,
  output logic                      win_hit,
  output logic [WIN_W-1:0]          win_off
);

  localparam int LA_W   = ADDR_W - SA_W;
  localparam int BASE_W = ADDR_W - WIN_W;
  localparam int PAGE_W = SA_W - WIN_W;

  logic [BASE_W-1:0] base_q;
  logic [LA_W-1:0]   la_q;
  logic              mem_en, use_sa;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      la_q   <= '0;
      mem_en <= 1'b0;
      use_sa <= 1'b0;
    end else begin
      if (cfg_we && !cfg_sel) base_q <= cfg_wdata[BASE_W-1:0];
      if (cfg_we && cfg_sel) begin
        mem_en <= cfg_wdata[EN_BIT];
        use_sa <= cfg_wdata[SEL_BIT];
      end
      if (bale) la_q <= la;
    end
  end

  logic full_strobe, low_strobe, hit_full, hit_low;

  assign full_strobe = !memr_n || !memw_n;
  assign low_strobe  = !smemr_n || !smemw_n;

  assign hit_full = mem_en && !use_sa && full_strobe &&
                    ({la_q, sa[SA_W-1:WIN_W]} == base_q);
  assign hit_low  = mem_en && use_sa && low_strobe &&
                    (base_q[BASE_W-1:PAGE_W] == '0) &&
                    (sa[SA_W-1:WIN_W] == base_q[PAGE_W-1:0]);

  assign win_hit = hit_full || hit_low;
  assign win_off = sa[WIN_W-1:0];

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (memr_n && memw_n && smemr_n && smemw_n) |-> !win_hit);  // R7
  AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && !cfg_wdata[EN_BIT]) |=> !win_hit);  // R2
  AST_LA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bale |=> $stable(la_q));  // R4
  AST_LA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    bale |=> (la_q == $past(la)));  // R4
  AST_LOW_MB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (use_sa && base_q[BASE_W-1:PAGE_W] != '0) |-> !win_hit);  // R6
  AST_LOW_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (use_sa && smemr_n && smemw_n) |-> !win_hit);  // R5

endmodule

// File: tb/isa_mem_window_tb.sv
module isa_mem_window_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic bale = 1'b0;
  logic [3:0] la = '0;
  logic [19:0] sa = '0;
  logic memr_n = 1'b1, memw_n = 1'b1, smemr_n = 1'b1, smemw_n = 1'b1;
  logic win_hit;
  logic [11:0] win_off;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  isa_mem_window u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bale(bale), .la(la), .sa(sa),
    .memr_n(memr_n), .memw_n(memw_n), .smemr_n(smemr_n), .smemw_n(smemw_n),
    .win_hit(win_hit), .win_off(win_off));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic latch_la(logic [3:0] v);
    @(negedge clk);
    la = v; bale = 1'b1;
    @(negedge clk);
    bale = 1'b0;
  endtask

  task automatic strobes(bit r, bit w, bit sr, bit sw);
    memr_n = ~r; memw_n = ~w; smemr_n = ~sr; smemw_n = ~sw;
    #1;
  endtask

  task automatic t_reset;
    strobes(1, 1, 1, 1);
    check("R1 hit in reset", win_hit, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 hit after reset", win_hit, 0);
    strobes(0, 0, 0, 0);
  endtask

  task automatic t_disabled;
    wr(0, 16'h0123);
    latch_la(4'h1);
    sa = 20'h23456;
    wr(1, 16'hFBFF);
    strobes(1, 0, 0, 0);
    check("R2 enable clear", win_hit, 0);
    check("R9 other bits ignored", win_hit, 0);
    strobes(0, 0, 0, 0);
  endtask

  task automatic t_full_hit;
    wr(1, 16'h0400);
    strobes(1, 0, 0, 0);
    check("R3 read hit", win_hit, 1);
    check("R8 offset", win_off, 12'h456);
    strobes(0, 1, 0, 0);
    check("R3 write hit", win_hit, 1);
    sa = 20'h23FFF; #1;
    check("R8 top offset", win_off, 12'hFFF);
    check("R3 top of window", win_hit, 1);
    sa = 20'h24000; #1;
    check("R10 page mismatch", win_hit, 0);
    sa = 20'h23456;
    strobes(0, 0, 0, 0);
  endtask

  task automatic t_la_hold;
    @(negedge clk);
    la = 4'h5;
    @(negedge clk);
    strobes(1, 0, 0, 0);
    check("R4 la ignored without bale", win_hit, 1);
    strobes(0, 0, 0, 0);
    latch_la(4'h5);
    strobes(1, 0, 0, 0);
    check("R10 upper nibble mismatch", win_hit, 0);
    strobes(0, 0, 0, 0);
    latch_la(4'h1);
  endtask

  task automatic t_strobe;
    strobes(0, 0, 0, 0);
    check("R7 no strobe", win_hit, 0);
    strobes(0, 0, 1, 1);
    check("R7 wrong-path strobe full", win_hit, 0);
    strobes(0, 0, 0, 0);
  endtask

  task automatic t_low_mb;
    wr(0, 16'h00AB);
    wr(1, 16'h0600);
    sa = 20'hAB456;
    strobes(0, 0, 1, 0);
    check("R5 low read hit", win_hit, 1);
    check("R8 low offset", win_off, 12'h456);
    strobes(0, 0, 0, 1);
    check("R5 low write hit", win_hit, 1);
    strobes(1, 1, 0, 0);
    check("R5 full strobes ignored", win_hit, 0);
    sa = 20'hAC456;
    strobes(0, 0, 1, 0);
    check("R10 low mismatch", win_hit, 0);
    sa = 20'hAB456;
    strobes(0, 0, 0, 0);
  endtask

  task automatic t_low_upper;
    wr(0, 16'h01AB);
    latch_la(4'h1);
    strobes(0, 0, 1, 1);
    check("R6 upper nibble nonzero", win_hit, 0);
    wr(1, 16'h0400);
    strobes(1, 0, 0, 0);
    check("R9 base bits 11..8 as address 23..20", win_hit, 1);
    strobes(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_disabled();
    t_full_hit();
    t_la_hold();
    t_strobe();
    t_low_mb();
    t_low_upper();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule